// File: doc/BRIEF.md
# Wrapping Word Address Counter

This block keeps the current array address of a 16K x 8 serial memory. A bus front end hands it the two address bytes of a command, upper byte then lower byte, through separate load strobes, and then pulses one of two step strobes for every data byte that moves. Steps taken while data is written move only the offset inside the current 64-byte page and wrap back to the start of that page. Steps taken while data is read advance the whole address and wrap from the last location of the array to the first.

The value is never cleared between transfers, so a read that supplies no address starts at the location after the last byte touched. The address is offered whole and also split into a page index and an offset within the page, so that a page-programming stage and a byte-select stage can each take the part they need.

Top module: `word_addr_ctr`

## Requirements
- R1: After reset the address is 0.
- R2: A high-byte load copies bits [5:0] of the high byte into address bits [13:8]; bits [7:6] of that byte have no effect, and address bits [7:0] keep their value.
- R3: A low-byte load copies all 8 bits of the low byte into address bits [7:0], and address bits [13:8] keep their value.
- R4: A write step with no load and no read step adds 1 to address bits [5:0], wrapping 63 to 0, while bits [13:6] keep their value.
- R5: A read step with no load adds 1 to the full 14-bit address, and 0x3FFF becomes 0x0000.
- R6: When any load strobe is high, no step takes effect in that cycle; a field whose strobe is low holds.
- R7: When both step strobes are high with no load, the read step (R5) applies.
- R8: With no strobe high the address keeps its value, so a following read step continues from the last byte touched.
- R9: The page index output equals address bits [13:6] and the page offset output equals address bits [5:0].
- R10: Both load strobes high in one cycle load both fields from their own byte inputs.
- R11: Every update lands on the clock edge where the strobe is sampled and is visible on the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_load | input | 1 | Load the upper address field from hi_byte |
| lo_load | input | 1 | Load the lower address field from lo_byte |
| hi_byte | input | 8 | Upper address byte as received |
| lo_byte | input | 8 | Lower address byte as received |
| step_wr | input | 1 | Advance within the page (write data byte) |
| step_rd | input | 1 | Advance across the array (read data byte) |
| addr | output | 14 | Current array address |
| page_idx | output | 8 | Page number, address bits [13:6] |
| page_off | output | 6 | Offset inside the page, address bits [5:0] |

## Verification
The bench builds the block with its default widths, a 14-bit address and a 6-bit page offset, because at that size every location is within reach: a single run of 16,384 read steps walks the whole array and crosses the top-to-zero wrap. Write steps are swept across more than a full page from several page bases, including the last page, so the offset wrap is seen with page bits of all ones. A pseudo-random mix of loads, steps and idle cycles, with high-byte values that set the two discarded bits, then exercises the priority rules against an arithmetic model.

// File: rtl/wac_pkg.sv
package wac_pkg;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_PAGE  = 2'd1,
    STEP_ARRAY = 2'd2
  } step_kind_e;

endpackage

// File: rtl/wac_cmd_decode.sv
module wac_cmd_decode
  import wac_pkg::*;
(
  input  logic       hi_load,
  input  logic       lo_load,
  input  logic       step_wr,
  input  logic       step_rd,
  output logic       load_any,
  output step_kind_e kind
);

  always_comb begin
    load_any = hi_load | lo_load;
    if (load_any)     kind = STEP_NONE;
    else if (step_rd) kind = STEP_ARRAY;
    else if (step_wr) kind = STEP_PAGE;
    else              kind = STEP_NONE;
  end

endmodule

// File: rtl/wac_load.sv
module wac_load #(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              hi_load,
  input  logic              lo_load,
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [BYTE_W-1:0] lo_byte,
  output logic [ADDR_W-1:0] nxt
);

  localparam int HI_W = ADDR_W - BYTE_W;

  logic [HI_W-1:0]   hi_field;
  logic [BYTE_W-1:0] lo_field;

  always_comb begin
    hi_field = hi_load ? hi_byte[HI_W-1:0] : cur[ADDR_W-1:BYTE_W];
    lo_field = lo_load ? lo_byte : cur[BYTE_W-1:0];
    nxt      = {hi_field, lo_field};
  end

endmodule

// File: rtl/wac_step.sv
module wac_step
  import wac_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6
) (
  input  logic [ADDR_W-1:0] cur,
  input  step_kind_e        kind,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap_page,
  output logic              wrap_array
);

  function automatic logic [ADDR_W-1:0] array_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] page_nxt;

  generate
    if (PAGE_W < ADDR_W) begin : g_paged
      function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
        logic [PAGE_W-1:0] off;
        off = a[PAGE_W-1:0] + PAGE_W'(1);
        return {a[ADDR_W-1:PAGE_W], off};
      endfunction
      assign page_nxt = page_next(cur);
    end else begin : g_flat
      assign page_nxt = array_next(cur);
    end
  endgenerate

  always_comb begin
    unique case (kind)
      STEP_PAGE:  nxt = page_nxt;
      STEP_ARRAY: nxt = array_next(cur);
      default:    nxt = cur;
    endcase
    wrap_page  = (kind == STEP_PAGE)  && (&cur[PAGE_W-1:0]);
    wrap_array = (kind == STEP_ARRAY) && (&cur);
  end

endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr
  import wac_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hi_load,
  input  logic                     lo_load,
  input  logic [BYTE_W-1:0]        hi_byte,
  input  logic [BYTE_W-1:0]        lo_byte,
  input  logic                     step_wr,
  input  logic                     step_rd,
  output logic [ADDR_W-1:0]        addr,
  output logic [ADDR_W-PAGE_W-1:0] page_idx,
  output logic [PAGE_W-1:0]        page_off
);

  logic              load_any;
  step_kind_e        kind;
  logic [ADDR_W-1:0] load_nxt;
  logic [ADDR_W-1:0] step_nxt;
  logic              wrap_page;
  logic              wrap_array;
  logic [ADDR_W-1:0] addr_q;

  wac_cmd_decode u_dec (
    .hi_load  (hi_load),
    .lo_load  (lo_load),
    .step_wr  (step_wr),
    .step_rd  (step_rd),
    .load_any (load_any),
    .kind     (kind)
  );

  wac_load #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_load (
    .cur     (addr_q),
    .hi_load (hi_load),
    .lo_load (lo_load),
    .hi_byte (hi_byte),
    .lo_byte (lo_byte),
    .nxt     (load_nxt)
  );

  wac_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .cur        (addr_q),
    .kind       (kind),
    .nxt        (step_nxt),
    .wrap_page  (wrap_page),
    .wrap_array (wrap_array)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (load_any) addr_q <= load_nxt;
    else               addr_q <= step_nxt;
  end

  assign addr     = addr_q;
  assign page_idx = addr_q[ADDR_W-1:PAGE_W];
  assign page_off = addr_q[PAGE_W-1:0];

endmodule

// File: rtl/wac_chk.sv
module wac_chk #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hi_load,
  input logic              lo_load,
  input logic [BYTE_W-1:0] hi_byte,
  input logic [BYTE_W-1:0] lo_byte,
  input logic              step_wr,
  input logic              step_rd,
  input logic [ADDR_W-1:0] addr,
  input logic              wrap_page,
  input logic              wrap_array
);

  localparam int HI_W = ADDR_W - BYTE_W;

  // R2
  hi_field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> addr[ADDR_W-1:BYTE_W] == $past(hi_byte[HI_W-1:0]));

  // R3
  lo_field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_load |=> addr[BYTE_W-1:0] == $past(lo_byte));

  // R6
  lo_only_holds_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_load && !hi_load) |=> addr[ADDR_W-1:BYTE_W] == $past(addr[ADDR_W-1:BYTE_W]));

  // R6
  hi_only_holds_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_load && !lo_load) |=> addr[BYTE_W-1:0] == $past(addr[BYTE_W-1:0]));

  // R4
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_wr && !step_rd && !hi_load && !lo_load) |=>
      (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
      (addr[PAGE_W-1:0] == PAGE_W'($past(addr[PAGE_W-1:0]) + 1'b1)));

  // R5
  array_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rd && !hi_load && !lo_load) |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R4
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_page |=> addr[PAGE_W-1:0] == '0);

  // R5
  array_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_array |=> addr == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_load && !lo_load && !step_wr && !step_rd) |=> $stable(addr));

endmodule

bind word_addr_ctr wac_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hi_load    (hi_load),
  .lo_load    (lo_load),
  .hi_byte    (hi_byte),
  .lo_byte    (lo_byte),
  .step_wr    (step_wr),
  .step_rd    (step_rd),
  .addr       (addr),
  .wrap_page  (wrap_page),
  .wrap_array (wrap_array)
);

// File: tb/sim_word_addr_ctr.sv
module sim_word_addr_ctr;

  localparam int SPAN = 16384;
  localparam int PAGE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_load = 1'b0, lo_load = 1'b0, step_wr = 1'b0, step_rd = 1'b0;
  logic [7:0]  hi_byte = '0, lo_byte = '0;
  logic [13:0] addr;
  logic [7:0]  page_idx;
  logic [5:0]  page_off;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  word_addr_ctr u0 (
    .clk(clk), .rst_n(rst_n), .hi_load(hi_load), .lo_load(lo_load),
    .hi_byte(hi_byte), .lo_byte(lo_byte), .step_wr(step_wr), .step_rd(step_rd),
    .addr(addr), .page_idx(page_idx), .page_off(page_off)
  );

  task automatic check(input string tag);
    checks++;
    if (int'(addr) != model) begin
      errors++;
      $display("FAIL %s addr actual %0h expected %0h", tag, addr, model);
    end
    checks++;
    if (int'(page_idx) != model / PAGE || int'(page_off) != model % PAGE) begin
      errors++;
      $display("FAIL R9 split actual %0h/%0h expected %0h/%0h",
               page_idx, page_off, model / PAGE, model % PAGE);
    end
  endtask

  // Drives at a falling edge, lets one rising edge pass, checks at the next falling edge (R11).
  task automatic cycle(input bit hl, input bit ll, input logic [7:0] hb, input logic [7:0] lb,
                       input bit w, input bit r, input string tag);
    hi_load = hl; lo_load = ll; hi_byte = hb; lo_byte = lb; step_wr = w; step_rd = r;
    @(posedge clk);
    if (hl || ll) begin
      if (hl) model = (int'(hb) % 64) * 256 + (model % 256);
      if (ll) model = (model / 256) * 256 + int'(lb);
    end else if (r) begin
      model = (model + 1) % SPAN;
    end else if (w) begin
      model = (model / PAGE) * PAGE + ((model % PAGE) + 1) % PAGE;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2: top bits of high byte set, must be discarded
    cycle(1, 0, 8'hFF, 8'h00, 0, 0, "R2 hi load 0xFF");
    cycle(1, 0, 8'hC5, 8'h00, 0, 0, "R2 hi load 0xC5");
    // R3
    cycle(0, 1, 8'h00, 8'hA7, 0, 0, "R3 lo load");
    // R10
    cycle(1, 1, 8'h7F, 8'hC0, 0, 0, "R10 both loads");
    // R4: sweep more than one page from the last page
    for (int i = 0; i < 70; i++) cycle(0, 0, 8'h00, 8'h00, 1, 0, "R4 page sweep top");
    cycle(1, 1, 8'h12, 8'h3E, 0, 0, "R10 reload");
    for (int i = 0; i < 66; i++) cycle(0, 0, 8'h00, 8'h00, 1, 0, "R4 page sweep mid");
    // R8 hold then continue
    for (int i = 0; i < 5; i++) cycle(0, 0, 8'h00, 8'h00, 0, 0, "R8 idle hold");
    cycle(0, 0, 8'h00, 8'h00, 0, 1, "R8 resume read");
    // R6 priority
    cycle(1, 0, 8'h05, 8'h00, 1, 1, "R6 hi load beats steps");
    cycle(0, 1, 8'h00, 8'hFF, 0, 1, "R6 lo load beats read");
    cycle(0, 1, 8'h00, 8'h3F, 1, 0, "R6 lo load beats write");
    // R7
    cycle(1, 1, 8'h00, 8'h3F, 0, 0, "R7 setup");
    cycle(0, 0, 8'h00, 8'h00, 1, 1, "R7 both steps cross page");
    // R5 full array walk with top wrap
    cycle(1, 1, 8'h3F, 8'hF0, 0, 0, "R5 setup near top");
    for (int i = 0; i < SPAN + 20; i++) cycle(0, 0, 8'h00, 8'h00, 0, 1, "R5 array sweep");
    // mixed pseudo-random traffic
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        bit hl, ll, w, r;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        hl = (lf[3:0] == 4'h0);
        ll = (lf[7:4] == 4'h1);
        w  = lf[8];
        r  = lf[9] & lf[10];
        cycle(hl, ll, lf[15:8], lf[7:0] ^ lf[15:8], w, r,
              (hl || ll) ? "R6 mixed load" : (r ? "R5 mixed read" : (w ? "R4 mixed write" : "R8 mixed idle")));
      end
    end
    // R1 reset mid-run
    rst_n = 1'b0;
    @(posedge clk);
    model = 0;
    @(negedge clk);
    check("R1 reset mid-run");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule